// File: doc/BRIEF.md
# Fine-Grained Multithreaded Issue Scheduler with Scouting

This block decides, every clock cycle, which hardware thread of an in-order, fine-grained multithreaded core may hand its next instruction to the decode stage. It keeps one small status machine for each thread. A thread is either ready, stalled on a long-latency blocking event, running speculatively past a data load miss (scouting), or frozen after its speculative work has been discarded. The thread count and the priority width are parameters.

Two issue policies can be selected. The small-latency policy rotates through the eligible threads, so any ready thread can issue on any cycle. The long-latency policy lets one thread keep the slot until it can no longer issue or a thread with strictly higher priority becomes eligible. With scouting enabled, a data load miss does not stall its thread. The thread keeps issuing so that later misses can be sent out early. Its results are kept from committing until the first miss resolves. A second load miss during scouting discards the speculative arithmetic work: the block raises a one-cycle rollback request for that thread and holds it until the first miss is resolved.

Top module: `mt_issue_sched`

## Requirements
- R1: After reset every thread is ready, every `commit_ok` bit is 1, `rb_req` is 0, and the first grant under the rotating policy goes to thread 0.
- R2: `issue_vld` is 1 only when the thread named by `issue_tid` has its `inst_vld` bit set and is ready or scouting. When no thread is eligible, `issue_vld` is 0.
- R3: With `pol_long` = 0 the grant goes to the first eligible thread found by counting upward from the last granted thread plus one, wrapping past the highest index to 0.
- R4: With `pol_long` = 1 the last granted thread keeps the grant while it stays eligible and no eligible thread has a strictly larger `prio` value.
- R5: With `pol_long` = 1, when the last granted thread is not eligible or is outranked, the grant goes to the eligible thread with the largest `prio` value. Ties go to the lowest index.
- R6: An asserted `blk_evt` on a ready thread, or an asserted `ld_miss` on a ready thread while `scout_en` is 0, stalls that thread from the next cycle on. A stalled thread is never granted, and its `commit_ok` stays 1.
- R7: With `scout_en` = 1, an `ld_miss` on a ready thread starts scouting from the next cycle. The thread can still be granted, and its `commit_ok` bit is 0.
- R8: `miss_done` on a stalled, scouting or frozen thread makes it ready on the next cycle, with `commit_ok` back to 1. On a ready thread, `miss_done` has no effect.
- R9: An `ld_miss` on a scouting thread (with no `miss_done` in the same cycle) asserts `rb_req` for exactly the next cycle, with `rb_tid` naming that thread. The thread is then frozen: never granted, `commit_ok` 0, until `miss_done`. If several threads roll back in the same cycle, the lowest index is reported. A `blk_evt` on a scouting thread freezes it without a rollback.
- R10: When `miss_done` and `ld_miss` or `blk_evt` arrive in the same cycle on a thread that is not ready, `miss_done` wins. The thread becomes ready and no rollback is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inst_vld | input | NTHR | Per-thread flag: an instruction is available to issue |
| blk_evt | input | NTHR | Per-thread blocking event (instruction miss or alternate-space access) |
| ld_miss | input | NTHR | Per-thread data load miss |
| miss_done | input | NTHR | Per-thread resolution of the outstanding first miss |
| prio | input | NTHR*PW | Per-thread priority, thread t in bits t*PW+PW-1 down to t*PW, larger is more urgent |
| pol_long | input | 1 | 0 selects the rotating small-latency policy, 1 the sticky long-latency policy |
| scout_en | input | 1 | 1 lets a load miss start scouting instead of stalling |
| issue_vld | output | 1 | A thread is granted this cycle |
| issue_tid | output | TW | Index of the granted thread |
| commit_ok | output | NTHR | Per-thread: instructions may commit |
| rb_req | output | 1 | One-cycle rollback request |
| rb_tid | output | TW | Thread that the rollback applies to |

## Verification
A thread whose status machine holds the wrong state shows it at the ports within one cycle. A stalled thread that is still granted, or a scouting thread whose `commit_ok` is not dropped, is visible in the same cycle the state is entered. A wrongly kept or lost rotation pointer or owner makes the very next grant differ from the expected thread. A dropped or doubled rollback appears in the cycle right after the second miss, as a missing or extra `rb_req` pulse. The bench compares every cycle of a long random run against a cycle model, so such a fault is reported in the cycle it first becomes visible.

// File: rtl/mt_sched_pkg.sv
package mt_sched_pkg;

    typedef enum logic [1:0] {
        TS_READY = 2'd0,
        TS_WAIT  = 2'd1,
        TS_SPEC  = 2'd2,
        TS_HOLD  = 2'd3
    } thr_st_e;

endpackage

// File: rtl/mt_thread_fsm.sv
module mt_thread_fsm
    import mt_sched_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scout_en,
    input  logic    ld_miss,
    input  logic    blk_evt,
    input  logic    miss_done,
    output thr_st_e st_o,
    output logic    rb_o
);

    typedef struct packed {
        thr_st_e st;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic rb_d;

    always_comb begin
        nxt_d = cur_q;
        rb_d  = 1'b0;
        unique case (cur_q.st)
            TS_READY: begin
                if (blk_evt) begin
                    nxt_d.st = TS_WAIT;
                end else if (ld_miss) begin
                    nxt_d.st = scout_en ? TS_SPEC : TS_WAIT;
                end
            end
            TS_WAIT: begin
                if (miss_done) nxt_d.st = TS_READY;
            end
            TS_SPEC: begin
                if (miss_done) begin
                    nxt_d.st = TS_READY;
                end else if (ld_miss) begin
                    nxt_d.st = TS_HOLD;
                    rb_d     = 1'b1;
                end else if (blk_evt) begin
                    nxt_d.st = TS_HOLD;
                end
            end
            TS_HOLD: begin
                if (miss_done) nxt_d.st = TS_READY;
            end
            default: nxt_d.st = TS_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: TS_READY};
        else        cur_q <= nxt_d;
    end

    assign st_o = cur_q.st;
    assign rb_o = rb_d;

endmodule

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
    parameter int N  = 4,
    parameter int TW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [TW-1:0] last,
    output logic          found,
    output logic [TW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = int'(last) + k;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = TW'(j);
            end
        end
    end

endmodule

// File: rtl/mt_prio_pick.sv
module mt_prio_pick #(
    parameter int N  = 4,
    parameter int TW = 2,
    parameter int PW = 2
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output logic            found,
    output logic [TW-1:0]   idx
);

    logic [PW-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || prio[i*PW +: PW] > best)) begin
                found = 1'b1;
                idx   = TW'(i);
                best  = prio[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/mt_issue_sched.sv
module mt_issue_sched
    import mt_sched_pkg::*;
#(
    parameter int NTHR = 4,
    parameter int PW   = 2,
    localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NTHR-1:0]   inst_vld,
    input  logic [NTHR-1:0]   blk_evt,
    input  logic [NTHR-1:0]   ld_miss,
    input  logic [NTHR-1:0]   miss_done,
    input  logic [NTHR*PW-1:0] prio,
    input  logic              pol_long,
    input  logic              scout_en,
    output logic              issue_vld,
    output logic [TW-1:0]     issue_tid,
    output logic [NTHR-1:0]   commit_ok,
    output logic              rb_req,
    output logic [TW-1:0]     rb_tid
);

    typedef struct packed {
        logic [TW-1:0] last;
        logic [TW-1:0] owner;
        logic          own_vld;
        logic          rb;
        logic [TW-1:0] rb_tid;
    } sched_t;

    sched_t  cur_q, nxt_d;

    thr_st_e         st   [NTHR];
    logic [NTHR-1:0] rb_hit;
    logic [NTHR-1:0] elig;
    logic [PW-1:0]   pr   [NTHR];

    genvar g;
    generate
        for (g = 0; g < NTHR; g++) begin : g_thr
            mt_thread_fsm u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .scout_en  (scout_en),
                .ld_miss   (ld_miss[g]),
                .blk_evt   (blk_evt[g]),
                .miss_done (miss_done[g]),
                .st_o      (st[g]),
                .rb_o      (rb_hit[g])
            );
            assign elig[g]      = inst_vld[g] && (st[g] == TS_READY || st[g] == TS_SPEC);
            assign commit_ok[g] = (st[g] == TS_READY) || (st[g] == TS_WAIT);
            assign pr[g]        = prio[g*PW +: PW];
        end
    endgenerate

    logic          rr_found, pp_found;
    logic [TW-1:0] rr_idx,   pp_idx;

    mt_rr_pick #(.N(NTHR), .TW(TW)) u_rr (
        .req   (elig),
        .last  (cur_q.last),
        .found (rr_found),
        .idx   (rr_idx)
    );

    mt_prio_pick #(.N(NTHR), .TW(TW), .PW(PW)) u_pp (
        .req   (elig),
        .prio  (prio),
        .found (pp_found),
        .idx   (pp_idx)
    );

    logic          outranked;
    logic          keep_owner;
    logic          gnt_vld;
    logic [TW-1:0] gnt_tid;

    always_comb begin
        outranked = 1'b0;
        for (int t = 0; t < NTHR; t++) begin
            if (elig[t] && pr[t] > pr[cur_q.owner]) outranked = 1'b1;
        end
        keep_owner = cur_q.own_vld && elig[cur_q.owner] && !outranked;

        if (pol_long) begin
            gnt_vld = keep_owner || pp_found;
            gnt_tid = keep_owner ? cur_q.owner : pp_idx;
        end else begin
            gnt_vld = rr_found;
            gnt_tid = rr_idx;
        end

        nxt_d = cur_q;
        if (gnt_vld) begin
            nxt_d.last    = gnt_tid;
            nxt_d.owner   = gnt_tid;
            nxt_d.own_vld = 1'b1;
        end
        nxt_d.rb     = |rb_hit;
        nxt_d.rb_tid = '0;
        for (int t = NTHR - 1; t >= 0; t--) begin
            if (rb_hit[t]) nxt_d.rb_tid = TW'(t);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{last: TW'(NTHR - 1), owner: '0, own_vld: 1'b0,
                       rb: 1'b0, rb_tid: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign issue_vld = gnt_vld;
    assign issue_tid = gnt_tid;
    assign rb_req    = cur_q.rb;
    assign rb_tid    = cur_q.rb_tid;

endmodule

// File: rtl/mt_issue_sched_chk.sv
module mt_issue_sched_chk #(
    parameter int NTHR = 4,
    parameter int PW   = 2,
    localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NTHR-1:0]   inst_vld,
    input logic [NTHR-1:0]   blk_evt,
    input logic [NTHR-1:0]   ld_miss,
    input logic [NTHR-1:0]   miss_done,
    input logic              scout_en,
    input logic              issue_vld,
    input logic [TW-1:0]     issue_tid,
    input logic [NTHR-1:0]   commit_ok,
    input logic              rb_req,
    input logic [TW-1:0]     rb_tid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (!rb_req && (&commit_ok))
                else $error("reset state wrong");
        end
    end

    assert_grant_has_inst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |-> inst_vld[issue_tid]);

    assert_rollback_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rb_req |-> (!commit_ok[rb_tid] && !(issue_vld && issue_tid == rb_tid)));

    genvar g;
    generate
        for (g = 0; g < NTHR; g++) begin : g_chk
            assert_stall_no_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (!scout_en && ld_miss[g] && !miss_done[g])
                |=> !(issue_vld && issue_tid == g));

            assert_resolve_commits_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (miss_done[g] && !commit_ok[g]) |=> commit_ok[g]);
        end
    endgenerate

endmodule

bind mt_issue_sched mt_issue_sched_chk #(.NTHR(NTHR), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inst_vld  (inst_vld),
    .blk_evt   (blk_evt),
    .ld_miss   (ld_miss),
    .miss_done (miss_done),
    .scout_en  (scout_en),
    .issue_vld (issue_vld),
    .issue_tid (issue_tid),
    .commit_ok (commit_ok),
    .rb_req    (rb_req),
    .rb_tid    (rb_tid)
);

// File: tb/mt_issue_sched_tb_top.sv
module mt_issue_sched_tb_top;

    localparam int NTHR = 4;
    localparam int PW   = 2;
    localparam int TW   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NTHR-1:0]   inst_vld = '0;
    logic [NTHR-1:0]   blk_evt = '0;
    logic [NTHR-1:0]   ld_miss = '0;
    logic [NTHR-1:0]   miss_done = '0;
    logic [NTHR*PW-1:0] prio = '0;
    logic              pol_long = 1'b0;
    logic              scout_en = 1'b0;
    logic              issue_vld;
    logic [TW-1:0]     issue_tid;
    logic [NTHR-1:0]   commit_ok;
    logic              rb_req;
    logic [TW-1:0]     rb_tid;

    mt_issue_sched #(.NTHR(NTHR), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .inst_vld(inst_vld), .blk_evt(blk_evt),
        .ld_miss(ld_miss), .miss_done(miss_done), .prio(prio),
        .pol_long(pol_long), .scout_en(scout_en), .issue_vld(issue_vld),
        .issue_tid(issue_tid), .commit_ok(commit_ok), .rb_req(rb_req),
        .rb_tid(rb_tid)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // reference model: 0 ready, 1 stalled, 2 scouting, 3 frozen
    int m_st [NTHR];
    int m_last, m_owner;
    bit m_own;
    bit m_rb;
    int m_rbt;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_elig(input int t);
        return inst_vld[t] && (m_st[t] == 0 || m_st[t] == 2);
    endfunction

    function automatic int m_pr(input int t);
        return int'(prio[t*PW +: PW]);
    endfunction

    function automatic int m_pick();
        if (!pol_long) begin
            for (int k = 1; k <= NTHR; k++) begin
                int j = (m_last + k) % NTHR;
                if (m_elig(j)) return j;
            end
            return -1;
        end else begin
            int best = -1;
            if (m_own && m_elig(m_owner)) begin
                bit hi = 0;
                for (int t = 0; t < NTHR; t++)
                    if (m_elig(t) && m_pr(t) > m_pr(m_owner)) hi = 1;
                if (!hi) return m_owner;
            end
            for (int t = 0; t < NTHR; t++)
                if (m_elig(t) && (best < 0 || m_pr(t) > m_pr(best))) best = t;
            return best;
        end
    endfunction

    function automatic bit m_commit(input int t);
        return m_st[t] == 0 || m_st[t] == 1;
    endfunction

    task automatic m_reset();
        for (int t = 0; t < NTHR; t++) m_st[t] = 0;
        m_last = NTHR - 1; m_owner = 0; m_own = 0; m_rb = 0; m_rbt = 0;
    endtask

    // compare one cycle, then advance model and DUT by one edge
    task automatic cyc(input string tag);
        int p;
        bit nrb;
        int nrbt;
        #1;
        p = m_pick();
        chk(issue_vld == (p >= 0), tag, int'(issue_vld), int'(p >= 0));
        if (p >= 0) chk(int'(issue_tid) == p, tag, int'(issue_tid), p);
        for (int t = 0; t < NTHR; t++)
            chk(commit_ok[t] == m_commit(t), tag, int'(commit_ok[t]), int'(m_commit(t)));
        chk(rb_req == m_rb, tag, int'(rb_req), int'(m_rb));
        if (m_rb) chk(int'(rb_tid) == m_rbt, tag, int'(rb_tid), m_rbt);
        @(posedge clk);
        nrb = 0; nrbt = 0;
        for (int t = NTHR - 1; t >= 0; t--) begin
            case (m_st[t])
                0: if (blk_evt[t]) m_st[t] = 1;
                   else if (ld_miss[t]) m_st[t] = scout_en ? 2 : 1;
                1: if (miss_done[t]) m_st[t] = 0;
                2: if (miss_done[t]) m_st[t] = 0;
                   else if (ld_miss[t]) begin m_st[t] = 3; nrb = 1; nrbt = t; end
                   else if (blk_evt[t]) m_st[t] = 3;
                default: if (miss_done[t]) m_st[t] = 0;
            endcase
        end
        m_rb = nrb; m_rbt = nrbt;
        if (p >= 0) begin m_last = p; m_owner = p; m_own = 1; end
        @(negedge clk);
    endtask

    task automatic clr();
        blk_evt = '0; ld_miss = '0; miss_done = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_reset();
        repeat (2) @(negedge clk);
        #1;
        chk(commit_ok == 4'hF, "R1 commit", int'(commit_ok), 15);
        chk(!rb_req, "R1 rollback", int'(rb_req), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 rotation, starting at thread 0 (R1)
        inst_vld = 4'hF;
        for (int k = 0; k < 5; k++) begin
            #1 chk(issue_vld && int'(issue_tid) == k % NTHR, "R3 rotation", int'(issue_tid), k % NTHR);
            cyc("R3");
        end
        inst_vld = 4'b1010;
        cyc("R3 skip");
        cyc("R3 skip");
        // R2 nothing eligible
        inst_vld = '0;
        #1 chk(!issue_vld, "R2 idle", int'(issue_vld), 0);
        cyc("R2");

        // R4/R5 long policy
        inst_vld = 4'hF; pol_long = 1'b1;
        cyc("R4 first");
        for (int k = 0; k < 3; k++) begin
            #1 chk(int'(issue_tid) == m_owner, "R4 sticky", int'(issue_tid), m_owner);
            cyc("R4");
        end
        prio = 8'b00_00_10_00;
        #1 chk(int'(issue_tid) == 1, "R5 preempt", int'(issue_tid), 1);
        cyc("R5");
        prio = 8'b00_01_00_01;
        #1 chk(int'(issue_tid) == 0, "R5 tie", int'(issue_tid), 0);
        cyc("R5");
        prio = '0; pol_long = 1'b0;

        // R6 stall without scouting
        scout_en = 1'b0; ld_miss[0] = 1'b1;
        cyc("R6"); clr();
        for (int k = 0; k < 4; k++) begin
            #1 chk(!(issue_vld && issue_tid == 0), "R6 stalled issue", int'(issue_tid), -1);
            chk(commit_ok[0], "R6 commit", int'(commit_ok[0]), 1);
            cyc("R6");
        end
        miss_done[0] = 1'b1; cyc("R8"); clr();
        inst_vld = 4'b0001;
        #1 chk(issue_vld && issue_tid == 0, "R8 resume", int'(issue_tid), 0);
        cyc("R8");

        // R7/R9 scouting and rollback
        inst_vld = 4'hF; scout_en = 1'b1; ld_miss[1] = 1'b1;
        cyc("R7"); clr();
        inst_vld = 4'b0010;
        #1 chk(!commit_ok[1], "R7 commit", int'(commit_ok[1]), 0);
        chk(issue_vld && issue_tid == 1, "R7 scouting issue", int'(issue_tid), 1);
        cyc("R7");
        ld_miss[1] = 1'b1; cyc("R9"); clr();
        #1 chk(rb_req && rb_tid == 1, "R9 pulse", int'(rb_tid), 1);
        chk(!issue_vld, "R9 held", int'(issue_vld), 0);
        cyc("R9");
        #1 chk(!rb_req, "R9 one cycle", int'(rb_req), 0);
        cyc("R9");
        miss_done[1] = 1'b1; cyc("R8"); clr();
        #1 chk(commit_ok[1] && issue_vld && issue_tid == 1, "R8 after hold", int'(issue_tid), 1);
        cyc("R8");

        // R10 resolve wins over a simultaneous second miss
        inst_vld = 4'hF; ld_miss[2] = 1'b1; cyc("R10"); clr();
        ld_miss[2] = 1'b1; miss_done[2] = 1'b1; cyc("R10"); clr();
        #1 chk(!rb_req && commit_ok[2], "R10 no rollback", int'(rb_req), 0);
        cyc("R10");

        // R6 blocking event stalls even with scouting on
        blk_evt[3] = 1'b1; cyc("R6 blk"); clr();
        inst_vld = 4'b1000;
        #1 chk(!issue_vld && commit_ok[3], "R6 blk stall", int'(issue_vld), 0);
        cyc("R6 blk");
        miss_done[3] = 1'b1; cyc("R8"); clr();

        // random phase
        begin
            int seed;
            seed = $urandom(32'h5EED);
            for (int n = 0; n < 4000; n++) begin
                inst_vld = NTHR'($urandom) | NTHR'($urandom);
                for (int t = 0; t < NTHR; t++) begin
                    ld_miss[t]   = ($urandom % 12) == 0;
                    blk_evt[t]   = ($urandom % 30) == 0;
                    miss_done[t] = ($urandom % 6) == 0;
                end
                if ($urandom % 16 == 0) prio = (NTHR*PW)'($urandom);
                if ($urandom % 80 == 0) pol_long = ~pol_long;
                if ($urandom % 60 == 0) scout_en = ~scout_en;
                cyc("RND R2 R3 R4 R5 R6 R7 R8 R9 R10");
            end
            clr();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule